// File: doc/BRIEF.md
# Wavefront Token Allocator

This block pairs N requesters with N resources in one combinational pass. Each cycle it takes a square request matrix, where bit [i][j] means requester i wants resource j. It returns a grant matrix that has at most one grant in any row and at most one in any column. Each row and each column owns one token. All tokens enter the grid at one wrapped diagonal, called the priority diagonal. A requesting cell that holds both of its tokens keeps them and is granted. Any other cell hands its row token to the cell on its right and its column token to the cell below, wrapping modulo N.

The wrap is unrolled into N diagonal steps, so the grid has no combinational loop. The priority diagonal is the only state in the block. It is a registered index that starts at 0 after reset. It moves on by one, modulo N, after every cycle in which any request is present, so over time every diagonal gets to go first. A switch or channel allocator uses the block by presenting its requests and taking the grants in the same cycle.

Top module: `wavefront_alloc`

## Requirements
- R1: A grant bit is set only where the matching request bit is set; bit [i][j] sits at index i*N+j of both vectors.
- R2: No row of the grant matrix holds more than one set bit.
- R3: No column of the grant matrix holds more than one set bit.
- R4: Every requesting cell on the current priority diagonal, meaning the cells with (i+j) mod N equal to the index, is granted.
- R5: With the index at 0 and N=4, rows 0..3 request {0,1,2}, {0,1}, {0} and {0,2}. The grants are then exactly [0][0], [3][2] and [1][1].
- R6: The priority index is 0 after reset. After a cycle with any request it becomes (index+1) mod N. After a cycle with no request it holds its value.
- R7: Every request that is not granted has a grant elsewhere in its row or in its column, so the matching is maximal.
- R8: Grants respond to the request inputs in the same cycle. An all-zero request gives an all-zero grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N*N | Request matrix, bit i*N+j = requester i wants resource j |
| gnt_o | output | N*N | Grant matrix, same layout as req_i |

## Verification
The only internal state is the priority index. If it is wrong, the first full-request cycle afterwards grants a different diagonal, because an all-ones request matrix is granted exactly along the priority diagonal. An index that skips, holds across a busy cycle or moves during an idle cycle therefore shows up within one cycle once every cell requests. A fault in token passing or the wrap shows up at once as a doubled row or column grant, a lost grant or a non-maximal matching on the same cycle's outputs.

// File: rtl/wf_pkg.sv
package wf_pkg;
    // Width of an index that selects one of n diagonals.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wf_cell.sv
module wf_cell (
    input  logic req_i,
    input  logic row_tok_i,
    input  logic col_tok_i,
    output logic gnt_o,
    output logic row_tok_o,
    output logic col_tok_o
);
    // The cell keeps both tokens only when it can use them.
    assign gnt_o     = req_i & row_tok_i & col_tok_i;
    assign row_tok_o = row_tok_i & ~gnt_o;
    assign col_tok_o = col_tok_i & ~gnt_o;
endmodule

// File: rtl/wf_rotate.sv
module wf_rotate #(
    parameter int N   = 4,
    parameter bit FWD = 1'b1,
    localparam int SW = wf_pkg::idx_width(N)
) (
    input  logic [N*N-1:0] mat_i,
    input  logic [SW-1:0]  sh_i,
    output logic [N*N-1:0] mat_o
);
    // Forward: out[i][c] = in[i][(c+sh)%N]; backward undoes it.
    always_comb begin
        mat_o = '0;
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < N; c++) begin
                int src;
                if (FWD) src = (c + int'(sh_i)) % N;
                else     src = (c - int'(sh_i) + N) % N;
                mat_o[i*N + c] = mat_i[i*N + src];
            end
        end
    end
endmodule

// File: rtl/wf_grid.sv
module wf_grid #(
    parameter int N = 4
) (
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] gnt_o
);
    // Tokens before step s; step 0 is the fixed first diagonal.
    logic [N-1:0] row_t [N+1];
    logic [N-1:0] col_t [N+1];

    assign row_t[0] = '1;
    assign col_t[0] = '1;

    for (genvar s = 0; s < N; s++) begin : g_step
        for (genvar i = 0; i < N; i++) begin : g_row
            localparam int C = (s - i + N) % N;
            wf_cell u_cell (
                .req_i     (req_i[i*N + C]),
                .row_tok_i (row_t[s][i]),
                .col_tok_i (col_t[s][C]),
                .gnt_o     (gnt_o[i*N + C]),
                .row_tok_o (row_t[s+1][i]),
                .col_tok_o (col_t[s+1][C])
            );
        end
    end

    logic unused_tail;
    assign unused_tail = ^{row_t[N], col_t[N]};
endmodule

// File: rtl/wavefront_alloc.sv
module wavefront_alloc #(
    parameter int N = 4,
    localparam int SW = wf_pkg::idx_width(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] gnt_o
);
    typedef struct packed {
        logic [SW-1:0] prio;
    } state_t;

    state_t st_d, st_q;
    logic [N*N-1:0] req_rot;
    logic [N*N-1:0] gnt_rot;
    logic [SW-1:0]  prio_q;

    assign prio_q = st_q.prio;

    always_comb begin
        st_d = st_q;
        if (|req_i) begin
            if (st_q.prio == SW'(N-1)) st_d.prio = '0;
            else                       st_d.prio = st_q.prio + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wf_rotate #(.N(N), .FWD(1'b1)) u_rot_in (
        .mat_i (req_i),
        .sh_i  (prio_q),
        .mat_o (req_rot)
    );

    wf_grid #(.N(N)) u_grid (
        .req_i (req_rot),
        .gnt_o (gnt_rot)
    );

    wf_rotate #(.N(N), .FWD(1'b0)) u_rot_out (
        .mat_i (gnt_rot),
        .sh_i  (prio_q),
        .mat_o (gnt_o)
    );
endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
    parameter int N = 4,
    localparam int SW = wf_pkg::idx_width(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N*N-1:0] req_i,
    input logic [N*N-1:0] gnt_o,
    input logic [SW-1:0]  prio_q
);
    logic [N-1:0] row_g [N];
    logic [N-1:0] col_g [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                row_g[i][j] = gnt_o[i*N + j];
                col_g[j][i] = gnt_o[i*N + j];
            end
        end
    end

    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0); // R1

    for (genvar k = 0; k < N; k++) begin : g_line
        AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(row_g[k])); // R2
        AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_g[k])); // R3
    end

    for (genvar i = 0; i < N; i++) begin : g_ci
        for (genvar j = 0; j < N; j++) begin : g_cj
            AST_DIAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (req_i[i*N+j] && (((i + j) % N) == int'(prio_q))) |-> gnt_o[i*N+j]); // R4
            AST_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
                (req_i[i*N+j] && !gnt_o[i*N+j]) |-> ((|row_g[i]) || (|col_g[j]))); // R7
        end
    end

    AST_PRIO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> (int'(prio_q) == ((int'($past(prio_q)) + 1) % N))); // R6
    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |=> $stable(prio_q)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> (gnt_o == '0)); // R8
endmodule

bind wavefront_alloc wf_checker #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .gnt_o  (gnt_o),
    .prio_q (prio_q)
);

// File: tb/wavefront_alloc_bench.sv
module wavefront_alloc_bench;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*N-1:0] req = '0;
    logic [N*N-1:0] gnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_prio = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    wavefront_alloc #(.N(N)) u_wavefront_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    task automatic check(input bit ok, input string tag, input logic [N*N-1:0] act,
                         input logic [N*N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N*N-1:0] diag(input int p);
        logic [N*N-1:0] m = '0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if ((i + j) % N == p) m[i*N + j] = 1'b1;
        return m;
    endfunction

    // Drive one cycle, check properties of the grant, model the index.
    task automatic apply(input logic [N*N-1:0] v);
        int rc, cc;
        bit row_ok, col_ok, max_ok;
        @(negedge clk);
        req = v;
        #1;
        check((gnt & ~v) == '0, "R1 grant without request", gnt, v);
        row_ok = 1; col_ok = 1; max_ok = 1;
        for (int k = 0; k < N; k++) begin
            rc = 0; cc = 0;
            for (int m = 0; m < N; m++) begin
                rc += gnt[k*N + m];
                cc += gnt[m*N + k];
            end
            if (rc > 1) row_ok = 0;
            if (cc > 1) col_ok = 0;
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (v[i*N+j] && !gnt[i*N+j]) begin
                    bit hit = 0;
                    for (int m = 0; m < N; m++)
                        if (gnt[i*N+m] || gnt[m*N+j]) hit = 1;
                    if (!hit) max_ok = 0;
                end
        check(row_ok, "R2 row has two grants", gnt, v);
        check(col_ok, "R3 column has two grants", gnt, v);
        check(max_ok, "R7 matching not maximal", gnt, v);
        check((v & diag(exp_prio) & ~gnt) == '0, "R4 diagonal request lost",
              gnt, v & diag(exp_prio));
        if (|v) exp_prio = (exp_prio + 1) % N;
    endtask

    task automatic t_reset;
        @(negedge clk);
        req = '0;
        #1;
        check(gnt == '0, "R8 idle grant after reset", gnt, '0);
        apply('1);
        check(gnt == diag(0), "R6 index 0 after reset", gnt, diag(0));
    endtask

    task automatic t_example;
        logic [N*N-1:0] v, e;
        while (exp_prio != 0) apply('1);
        v = '0;
        v[0*N+0] = 1; v[0*N+1] = 1; v[0*N+2] = 1;
        v[1*N+0] = 1; v[1*N+1] = 1;
        v[2*N+0] = 1;
        v[3*N+0] = 1; v[3*N+2] = 1;
        e = '0;
        e[0*N+0] = 1; e[3*N+2] = 1; e[1*N+1] = 1;
        apply(v);
        check(gnt == e, "R5 worked example", gnt, e);
    endtask

    task automatic t_rotate;
        for (int c = 0; c < 2*N; c++) begin
            int p = exp_prio;
            apply('1);
            check(gnt == diag(p), "R6 full request follows index", gnt, diag(p));
        end
    endtask

    task automatic t_idle;
        int p;
        for (int c = 0; c < 3; c++) begin
            apply('0);
            check(gnt == '0, "R8 idle gives no grant", gnt, '0);
        end
        p = exp_prio;
        apply('1);
        check(gnt == diag(p), "R6 index held while idle", gnt, diag(p));
    endtask

    task automatic t_single;
        for (int b = 0; b < N*N; b++) begin
            logic [N*N-1:0] v = '0;
            v[b] = 1'b1;
            apply(v);
            check(gnt == v, "R7 lone request granted", gnt, v);
        end
    endtask

    task automatic t_random;
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[N*N-1:0] & {lfsr[7:0], lfsr[15:8]});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_rotate();
        t_idle();
        t_single();
        t_random();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule